// File: doc/BRIEF.md
# 1-Wire Slave Bit-Slot Front End

This block is the timing layer of a 1-Wire slave. It observes the open-drain data line through a synchronizer and pulls it low through a single enable output. Every timed action starts from a falling edge that the master makes, or from the rising edge that ends a reset pulse. A microsecond tick is derived from the system clock frequency parameter, and all windows are counted in whole microseconds from the edge that opened them.

A low period of more than the reset threshold is treated as a bus reset. After the line rises, the block reports a reset strobe, waits a fixed delay, and then drives a presence pulse of fixed width. Any other falling edge opens a time slot. If the upper layer has a transmit request pending at that edge, the slot is a read slot: the request is acknowledged, and a 0 bit is sent by holding the line low for a fixed time. Otherwise the line level is sampled at a fixed point and handed upward with a valid strobe. Byte assembly and command handling belong to the layer above.

Top module: `ow_slot_if`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pull_o`, `rx_valid_o`, `tx_ack_o` and `bus_rst_o` are all 0.
- R2: A reset is recognized only when the line stays low for more than RST_MIN_US microseconds (480). `bus_rst_o` then pulses for exactly one cycle, SYNC_STAGES+1 cycles after the line rises. A shorter low period yields no strobe.
- R3: The presence pulse starts PRES_WAIT_US microseconds (30) plus SYNC_STAGES+1 cycles after the line rises at the end of a reset.
- R4: The presence pulse holds `pull_o` high for exactly PRES_LEN_US microseconds (120).
- R5: In a write slot, `rx_valid_o` pulses once, SAMPLE_US microseconds (30) plus SYNC_STAGES+1 cycles after the falling edge. `rx_bit_o` is 1 when the master released the line within SAMPLE_US microseconds of the edge, and 0 otherwise.
- R6: In a read slot with `tx_bit_i` = 0, `pull_o` rises SYNC_STAGES+1 cycles after the falling edge and stays high for exactly RD_HOLD_US microseconds (30). This covers the 15 µs read point and releases well before 60 µs.
- R7: In a read slot with `tx_bit_i` = 1, `pull_o` stays low. No read slot produces an `rx_valid_o` pulse.
- R8: A slot is a read slot when `tx_req_i` is 1 in the cycle in which the falling edge is detected. `tx_ack_o` then pulses for exactly one cycle, SYNC_STAGES+1 cycles after the edge.
- R9: While a presence delay or presence pulse is in progress, master activity on the line neither opens a slot nor shifts the presence timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Sensed level of the 1-Wire data line |
| pull_o | output | 1 | Pull-low enable for the open-drain driver |
| bus_rst_o | output | 1 | One-cycle strobe: a bus reset has ended |
| rx_bit_o | output | 1 | Bit received in the last write slot |
| rx_valid_o | output | 1 | One-cycle strobe qualifying `rx_bit_o` |
| tx_bit_i | input | 1 | Bit to send in the next read slot |
| tx_req_i | input | 1 | Make the next slot a read slot |
| tx_ack_o | output | 1 | One-cycle strobe: the pending bit was taken by a slot |

## Verification
The bench builds the block with CLK_HZ = 4 MHz, so each microsecond is four clock cycles and a full reset with its presence pulse fits in a few thousand cycles. At this rate every write-slot low width, from one cycle up past the sample point, can be swept cycle by cycle at the sample boundary. Reset pulses are placed exactly at, and one cycle beyond, the 480 µs threshold. Each expected delay and width is the microsecond figure times four plus the three-cycle synchronizer latency, so a one-microsecond error in any window shows up as a four-cycle mismatch.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SLOT  = 2'd1,
    ST_PWAIT = 2'd2,
    ST_PDRV  = 2'd3
  } ow_state_t;

  function automatic int ow_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_s,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b1;
        else     chain_q[0] <= line_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b1;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign line_s = chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= line_s;
  end

  assign fall = prev_q & ~line_s;

  AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (rst)
    fall |-> $past(line_s)); // R5

endmodule

// File: rtl/ow_us_timer.sv
module ow_us_timer #(
  parameter int DIV    = 50,
  parameter int US_MAX = 480
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  output logic                       tick,
  output logic [$clog2(US_MAX+1)-1:0] us
);

  localparam int SW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int UW = $clog2(US_MAX+1);

  logic [SW-1:0] sub_q;
  logic [UW-1:0] us_q;

  assign tick = (sub_q == SW'(DIV-1));
  assign us   = us_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sub_q <= '0;
      us_q  <= '0;
    end else begin
      sub_q <= tick ? '0 : sub_q + 1'b1;
      if (tick && us_q != UW'(US_MAX))
        us_q <= us_q + 1'b1;
    end
  end

  AST_US_BOUND: assert property (@(posedge clk) disable iff (rst)
    us_q <= UW'(US_MAX)); // R2

endmodule

// File: rtl/ow_slot_ctrl.sv
module ow_slot_ctrl
  import ow_pkg::*;
#(
  parameter int UW           = 9,
  parameter int RST_MIN_US   = 480,
  parameter int SAMPLE_US    = 30,
  parameter int RD_HOLD_US   = 30,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_LEN_US  = 120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_s,
  input  logic          fall,
  input  logic          tick,
  input  logic [UW-1:0] us,
  output logic          timer_clr,
  input  logic          tx_bit_i,
  input  logic          tx_req_i,
  output logic          pull_o,
  output logic          bus_rst_o,
  output logic          rx_bit_o,
  output logic          rx_valid_o,
  output logic          tx_ack_o
);

  ow_state_t state_q, state_n;
  logic rd_slot_q, rd_slot_n;
  logic sampled_q, sampled_n;
  logic rst_seen_q, rst_seen_n;
  logic pull_q, pull_n;
  logic rx_bit_q, rx_bit_n;
  logic rx_valid_n, ack_n, brst_n;
  logic rx_valid_q, ack_q, brst_q;

  logic at_sample, at_hold, at_rst, at_pwait, at_plen;
  assign at_sample = tick && (us == UW'(SAMPLE_US-1));
  assign at_hold   = tick && (us == UW'(RD_HOLD_US-1));
  assign at_rst    = tick && (us == UW'(RST_MIN_US-1));
  assign at_pwait  = tick && (us == UW'(PRES_WAIT_US-1));
  assign at_plen   = tick && (us == UW'(PRES_LEN_US-1));

  always_comb begin
    state_n    = state_q;
    rd_slot_n  = rd_slot_q;
    sampled_n  = sampled_q;
    rst_seen_n = rst_seen_q;
    pull_n     = pull_q;
    rx_bit_n   = rx_bit_q;
    rx_valid_n = 1'b0;
    ack_n      = 1'b0;
    brst_n     = 1'b0;
    timer_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall) begin
          state_n    = ST_SLOT;
          timer_clr  = 1'b1;
          sampled_n  = 1'b0;
          rst_seen_n = 1'b0;
          rd_slot_n  = tx_req_i;
          ack_n      = tx_req_i;
          pull_n     = tx_req_i & ~tx_bit_i;
        end
      end
      ST_SLOT: begin
        if (pull_q && at_hold)
          pull_n = 1'b0;
        if (!sampled_q && at_sample) begin
          sampled_n = 1'b1;
          if (!rd_slot_q) begin
            rx_valid_n = 1'b1;
            rx_bit_n   = line_s;
          end
        end
        if (!line_s && at_rst)
          rst_seen_n = 1'b1;
        if (line_s && sampled_q) begin
          if (rst_seen_q) begin
            state_n   = ST_PWAIT;
            timer_clr = 1'b1;
            brst_n    = 1'b1;
          end else begin
            state_n = ST_IDLE;
          end
        end
      end
      ST_PWAIT: begin
        if (at_pwait) begin
          state_n   = ST_PDRV;
          timer_clr = 1'b1;
          pull_n    = 1'b1;
        end
      end
      ST_PDRV: begin
        if (at_plen) begin
          state_n = ST_IDLE;
          pull_n  = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      rd_slot_q  <= 1'b0;
      sampled_q  <= 1'b0;
      rst_seen_q <= 1'b0;
      pull_q     <= 1'b0;
      rx_bit_q   <= 1'b1;
      rx_valid_q <= 1'b0;
      ack_q      <= 1'b0;
      brst_q     <= 1'b0;
    end else begin
      state_q    <= state_n;
      rd_slot_q  <= rd_slot_n;
      sampled_q  <= sampled_n;
      rst_seen_q <= rst_seen_n;
      pull_q     <= pull_n;
      rx_bit_q   <= rx_bit_n;
      rx_valid_q <= rx_valid_n;
      ack_q      <= ack_n;
      brst_q     <= brst_n;
    end
  end

  assign pull_o     = pull_q;
  assign bus_rst_o  = brst_q;
  assign rx_bit_o   = rx_bit_q;
  assign rx_valid_o = rx_valid_q;
  assign tx_ack_o   = ack_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> !pull_q); // R6
  AST_PRES_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    bus_rst_o |-> !pull_o); // R3
  AST_RX_NOT_IN_READ: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> !rd_slot_q); // R7

endmodule

// File: rtl/ow_slot_if.sv
module ow_slot_if
  import ow_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_MIN_US   = 480,
  parameter int SAMPLE_US    = 30,
  parameter int RD_HOLD_US   = 30,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_LEN_US  = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic pull_o,
  output logic bus_rst_o,
  output logic rx_bit_o,
  output logic rx_valid_o,
  input  logic tx_bit_i,
  input  logic tx_req_i,
  output logic tx_ack_o
);

  localparam int DIV    = CLK_HZ / 1_000_000;
  localparam int US_MAX = ow_max(ow_max(RST_MIN_US, SAMPLE_US),
                                 ow_max(ow_max(RD_HOLD_US, PRES_WAIT_US), PRES_LEN_US));
  localparam int UW     = $clog2(US_MAX+1);

  logic          line_s, fall, tick, timer_clr;
  logic [UW-1:0] us;

  ow_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .line_i(line_i), .line_s(line_s), .fall(fall)
  );

  ow_us_timer #(.DIV(DIV), .US_MAX(US_MAX)) timer_i (
    .clk(clk), .rst(rst), .clr(timer_clr), .tick(tick), .us(us)
  );

  ow_slot_ctrl #(
    .UW(UW), .RST_MIN_US(RST_MIN_US), .SAMPLE_US(SAMPLE_US),
    .RD_HOLD_US(RD_HOLD_US), .PRES_WAIT_US(PRES_WAIT_US), .PRES_LEN_US(PRES_LEN_US)
  ) ctrl_i (
    .clk(clk), .rst(rst), .line_s(line_s), .fall(fall), .tick(tick), .us(us),
    .timer_clr(timer_clr), .tx_bit_i(tx_bit_i), .tx_req_i(tx_req_i),
    .pull_o(pull_o), .bus_rst_o(bus_rst_o), .rx_bit_o(rx_bit_o),
    .rx_valid_o(rx_valid_o), .tx_ack_o(tx_ack_o)
  );

  AST_RST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
    bus_rst_o |=> !bus_rst_o); // R2
  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o); // R5
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tx_ack_o |=> !tx_ack_o); // R8
  AST_NO_RX_WHILE_PULL: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> !pull_o); // R7

endmodule

// File: tb/ow_slot_if_tb.sv
module ow_slot_if_tb_top;

  localparam int HZ  = 4_000_000;
  localparam int D   = HZ / 1_000_000;
  localparam int LAT = 3;
  localparam int RMIN = 480, SMP = 30, RH = 30, PW = 30, PL = 120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_low = 1'b0;
  logic tx_bit = 1'b1, tx_req = 1'b0;
  logic pull, brst, rx_bit, rx_valid, ack;
  logic line;

  assign line = ~(master_low | pull);

  always #10 clk = ~clk;

  ow_slot_if #(.CLK_HZ(HZ)) dut_i (
    .clk(clk), .rst(rst), .line_i(line), .pull_o(pull), .bus_rst_o(brst),
    .rx_bit_o(rx_bit), .rx_valid_o(rx_valid), .tx_bit_i(tx_bit),
    .tx_req_i(tx_req), .tx_ack_o(ack)
  );

  int n_chk = 0, n_bad = 0;
  int n_rx, rx_at, n_pull, pull_first, n_ack, ack_at, n_rst, rst_at;
  logic last_rx;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive the line low for m cycles, observe for w cycles in total
  task automatic run_low(input int m, input bit req, input bit tb, input int w,
                         input int glitch_at);
    n_rx = 0; rx_at = -1; n_pull = 0; pull_first = -1;
    n_ack = 0; ack_at = -1; n_rst = 0; rst_at = -1; last_rx = 1'bx;
    @(negedge clk);
    master_low = 1'b1;
    tx_req = req;
    tx_bit = tb;
    for (int k = 1; k <= w; k++) begin
      @(negedge clk);
      if (rx_valid) begin n_rx++; rx_at = k; last_rx = rx_bit; end
      if (pull) begin n_pull++; if (pull_first < 0) pull_first = k; end
      if (ack) begin n_ack++; ack_at = k; tx_req = 1'b0; end
      if (brst) begin n_rst++; rst_at = k; end
      if (k == m) master_low = 1'b0;
      if (glitch_at > 0 && k == glitch_at) master_low = 1'b1;
      if (glitch_at > 0 && k == glitch_at + 8) master_low = 1'b0;
    end
    tx_req = 1'b0;
  endtask

  task automatic write_slot(input int m);
    bit exp_bit;
    exp_bit = (m <= SMP*D);
    run_low(m, 1'b0, 1'b1, m + 60*D, 0);
    chk(n_rx == 1, "R5 rx count", n_rx, 1);
    chk(last_rx === exp_bit, "R5 rx bit", int'(last_rx), int'(exp_bit));
    chk(rx_at == SMP*D + LAT, "R5 sample time", rx_at, SMP*D + LAT);
    chk(n_pull == 0 && n_ack == 0 && n_rst == 0, "R5 no side effect", n_pull + n_ack + n_rst, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(!pull && !rx_valid && !ack && !brst, "R1 in reset", int'({pull, rx_valid, ack, brst}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!pull && !rx_valid && !ack && !brst, "R1 after reset", int'({pull, rx_valid, ack, brst}), 0);
    repeat (10) @(negedge clk);

    // R5: write slots, fine sweep around the sample point, coarse elsewhere
    for (int m = 1; m <= 60; m += 7) write_slot(m);
    for (int m = SMP*D - 3; m <= SMP*D + 3; m++) write_slot(m);
    for (int m = 60*D; m <= 120*D; m += 10*D) write_slot(m);

    // R6, R8: read zero
    for (int m = 1; m <= 1 + 2*D; m += D) begin
      run_low(m, 1'b1, 1'b0, 80*D, 0);
      chk(pull_first == LAT, "R6 pull start", pull_first, LAT);
      chk(n_pull == RH*D, "R6 pull width", n_pull, RH*D);
      chk(n_ack == 1 && ack_at == LAT, "R8 ack", ack_at, LAT);
      chk(n_rx == 0, "R7 no rx in read", n_rx, 0);
    end

    // R7, R8: read one
    for (int m = 1; m <= 1 + 2*D; m += D) begin
      run_low(m, 1'b1, 1'b1, 80*D, 0);
      chk(n_pull == 0, "R7 no pull for one", n_pull, 0);
      chk(n_rx == 0, "R7 no rx in read", n_rx, 0);
      chk(n_ack == 1 && ack_at == LAT, "R8 ack", ack_at, LAT);
    end

    // R2: at threshold no reset
    run_low(RMIN*D, 1'b0, 1'b1, RMIN*D + 200*D, 0);
    chk(n_rst == 0, "R2 no reset at threshold", n_rst, 0);
    chk(n_pull == 0, "R2 no presence at threshold", n_pull, 0);

    // R2, R3, R4: one cycle beyond and well beyond
    for (int t = 0; t < 2; t++) begin
      int m;
      m = (t == 0) ? RMIN*D + 1 : 600*D;
      run_low(m, 1'b0, 1'b1, m + 200*D, 0);
      chk(n_rst == 1 && rst_at == m + LAT, "R2 reset strobe", rst_at, m + LAT);
      chk(pull_first == m + LAT + PW*D, "R3 presence delay", pull_first, m + LAT + PW*D);
      chk(n_pull == PL*D, "R4 presence width", n_pull, PL*D);
    end

    // R9: master glitches during presence wait and presence pulse
    for (int g = 0; g < 2; g++) begin
      int m, ga;
      m  = RMIN*D + 40;
      ga = (g == 0) ? m + 10*D : m + 60*D;
      run_low(m, 1'b0, 1'b1, m + 200*D, ga);
      chk(n_rx == 1, "R9 glitch opens no slot", n_rx, 1);
      chk(pull_first == m + LAT + PW*D, "R9 presence delay kept", pull_first, m + LAT + PW*D);
      chk(n_pull == PL*D, "R9 presence width kept", n_pull, PL*D);
    end

    // bus works normally afterwards
    write_slot(4);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule